// File: doc/BRIEF.md
# Framed Byte Command Decoder with Staged Video Registers

This block sits behind a byte-wide link and turns a stream of framed commands into configuration state and copy requests. Every command opens with the marker byte 0xAF, followed by one opcode byte. A register-write command carries a register address and a data byte. A copy command carries seven operand bytes: a source address, a pixel count and a destination address. The decoder consumes one byte per cycle through a valid/ready handshake.

Register writes land in a shadow file. While the video registers are unlocked, each write also reaches the active set at once. A write of 0x00 to address 0xFF locks the video registers, so later writes only stage values. A write of 0xFF to address 0xFF unlocks them and moves the whole shadow file into the active set in one cycle, so a complete mode change appears all at once. The colour-depth byte and the two 24-bit base addresses are also presented as decoded fields.

A parsed copy command is held on its own request port until the consumer accepts it. The input stream stalls while a request is pending. A bad marker byte or an unknown opcode raises a sticky error flag. The decoder then discards bytes until the next marker.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, in_ready is 1, copy_valid is 0, cmd_error is 0, vid_locked is 0, and every active register reads 0.
- R2: While unlocked, the sequence 0xAF, 0x20, A, V with A below REG_COUNT sets active register A (bits A*8 +: 8 of active_regs) to V on the clock edge that accepts V. No other register changes.
- R3: The write 0xAF, 0x20, 0xFF, 0x00 sets vid_locked. While it stays set, register writes leave active_regs unchanged.
- R4: The write 0xAF, 0x20, 0xFF, 0xFF clears vid_locked. On that same edge, every value staged while locked appears on active_regs.
- R5: depth_sel shows active register 0x00. base_16bpp is {reg 0x20, reg 0x21, reg 0x22} and base_8bpp is {reg 0x26, reg 0x27, reg 0x28}, with the lowest address as the most significant byte.
- R6: The sequence 0xAF, 0x6A, S2, S1, S0, N, D2, D1, D0 raises copy_valid on the edge that accepts D0. It presents copy_src = {S2,S1,S0}, copy_count = N and copy_dst = {D2,D1,D0}.
- R7: While copy_valid is 1 and copy_ready is 0, the copy fields hold steady and in_ready is 0. copy_valid clears on the edge where copy_ready is seen.
- R8: A 0xAF in the opcode position counts as a fresh marker. It raises no error, and the command that follows is decoded normally.
- R9: A byte other than 0xAF in the marker position sets cmd_error. Bytes up to the next 0xAF are discarded, so a register write embedded in them has no effect.
- R10: An opcode other than 0x20, 0x6A or 0xAF sets cmd_error, and the bytes that follow are discarded until the next 0xAF.
- R11: A write to address 0xFF with any value other than 0x00 or 0xFF leaves vid_locked unchanged. A write to an address from REG_COUNT to 0xFE changes no active or staged register.
- R12: cmd_error stays set until reset, even after later commands decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| active_regs | output | REG_COUNT*8 | Active register set, register i at bits i*8 +: 8 |
| depth_sel | output | 8 | Active colour-depth selector (register 0x00) |
| base_16bpp | output | 24 | Active 16 bpp base address |
| base_8bpp | output | 24 | Active 8 bpp base address |
| vid_locked | output | 1 | Video registers locked |
| copy_valid | output | 1 | Copy request pending |
| copy_ready | input | 1 | Consumer accepts the copy request |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| cmd_error | output | 1 | Sticky framing or opcode error |

## Verification
The bench builds the decoder with REG_COUNT = 64. This makes a full sweep over every implemented register affordable, both written directly and staged behind the lock. It also leaves addresses 0x40 to 0xFE reachable as out-of-range targets. The copy port is run with consumer delays from zero to several cycles, with a register write queued behind the pending request. Error recovery is covered both from a bad marker and from an unknown opcode, each with a reset in between.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam logic [7:0] SYNC_BYTE  = 8'hAF;
  localparam logic [7:0] OP_REGWR   = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_ADDR  = 8'hFF;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;

  localparam int DEPTH_IDX = 8'h00;
  localparam int B16_IDX   = 8'h20;
  localparam int B8_IDX    = 8'h26;
  localparam int MIN_REGS  = B8_IDX + 3;

  localparam int COPY_LEN  = 7;

  typedef enum logic [2:0] {
    ST_SYNC, ST_OPC, ST_RADDR, ST_RVAL, ST_COPY, ST_DROP
  } pstate_t;

  typedef struct packed {
    logic [23:0] src;
    logic [7:0]  cnt;
    logic [23:0] dst;
  } copy_req_t;
endpackage

// File: rtl/csd_parser.sv
module csd_parser
  import csd_pkg::*;
#(
  parameter int OPND_LEN = COPY_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_i,
  input  logic       take_i,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       cp_byte_en_o,
  output logic       cp_last_o,
  output logic       err_o
);
  localparam int IW = (OPND_LEN > 1) ? $clog2(OPND_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(OPND_LEN - 1);

  pstate_t       st_q;
  logic [7:0]    addr_q;
  logic [IW-1:0] idx_q;
  logic          err_q;

  always_comb begin
    wr_en_o      = take_i && (st_q == ST_RVAL);
    wr_addr_o    = addr_q;
    wr_data_o    = byte_i;
    cp_byte_en_o = take_i && (st_q == ST_COPY);
    cp_last_o    = cp_byte_en_o && (idx_q == LAST_IDX);
  end

  assign err_o = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SYNC;
      addr_q <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else if (take_i) begin
      case (st_q)
        ST_SYNC, ST_DROP: begin
          if (byte_i == SYNC_BYTE) begin
            st_q <= ST_OPC;
          end else begin
            if (st_q == ST_SYNC) err_q <= 1'b1;
            st_q <= ST_DROP;
          end
        end
        ST_OPC: begin
          if (byte_i == OP_REGWR) begin
            st_q <= ST_RADDR;
          end else if (byte_i == OP_COPY) begin
            st_q  <= ST_COPY;
            idx_q <= '0;
          end else if (byte_i == SYNC_BYTE) begin
            st_q <= ST_OPC;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_DROP;
          end
        end
        ST_RADDR: begin
          addr_q <= byte_i;
          st_q   <= ST_RVAL;
        end
        ST_RVAL: st_q <= ST_SYNC;
        ST_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) st_q <= ST_SYNC;
        end
        default: st_q <= ST_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/csd_regfile.sv
module csd_regfile
  import csd_pkg::*;
#(
  parameter int REG_COUNT = 64,
  parameter int DW        = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en_i,
  input  logic [7:0]              wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic                    locked_o,
  output logic [REG_COUNT*DW-1:0] act_flat_o
);
  localparam int FLAT_W = REG_COUNT * DW;

  logic              locked_q;
  logic              is_lock;
  logic              in_range;
  logic              reg_wr;
  logic              unlock_now;
  logic [FLAT_W-1:0] shadow_flat;
  logic [FLAT_W-1:0] active_flat;

  always_comb begin
    is_lock    = (wr_addr_i == LOCK_ADDR);
    in_range   = ({1'b0, wr_addr_i} < 9'(REG_COUNT));
    reg_wr     = wr_en_i && !is_lock && in_range;
    unlock_now = wr_en_i && is_lock && (wr_data_i[7:0] == UNLOCK_VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (wr_en_i && is_lock) begin
      if (wr_data_i[7:0] == LOCK_VAL)        locked_q <= 1'b1;
      else if (wr_data_i[7:0] == UNLOCK_VAL) locked_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic hit;
    assign hit = reg_wr && (wr_addr_i == 8'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_flat[i*DW +: DW] <= '0;
      end else if (hit) begin
        shadow_flat[i*DW +: DW] <= wr_data_i;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active_flat[i*DW +: DW] <= '0;
      end else if (unlock_now) begin
        active_flat[i*DW +: DW] <= shadow_flat[i*DW +: DW];
      end else if (hit && !locked_q) begin
        active_flat[i*DW +: DW] <= wr_data_i;
      end
    end
  end

  assign locked_o   = locked_q;
  assign act_flat_o = active_flat;
endmodule

// File: rtl/csd_copy_port.sv
module csd_copy_port
  import csd_pkg::*;
#(
  parameter int OPND_LEN = COPY_LEN
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  byte_i,
  input  logic        byte_en_i,
  input  logic        last_i,
  input  logic        req_ready_i,
  output logic        req_valid_o,
  output copy_req_t   req_o
);
  localparam int STG_W = OPND_LEN * 8;

  logic [STG_W-1:0] stage_q;
  logic [STG_W-1:0] stage_nx;
  logic             valid_q;
  copy_req_t        req_q;

  assign stage_nx = {stage_q[STG_W-9:0], byte_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      valid_q <= 1'b0;
      req_q   <= '0;
    end else begin
      if (byte_en_i) stage_q <= stage_nx;
      if (byte_en_i && last_i) begin
        req_q   <= copy_req_t'(stage_nx[$bits(copy_req_t)-1:0]);
        valid_q <= 1'b1;
      end else if (valid_q && req_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign req_valid_o = valid_q;
  assign req_o       = req_q;
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import csd_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  output logic [REG_COUNT*8-1:0] active_regs,
  output logic [7:0]             depth_sel,
  output logic [23:0]            base_16bpp,
  output logic [23:0]            base_8bpp,
  output logic                   vid_locked,
  output logic                   copy_valid,
  input  logic                   copy_ready,
  output logic [23:0]            copy_src,
  output logic [7:0]             copy_count,
  output logic [23:0]            copy_dst,
  output logic                   cmd_error
);
  localparam int FLAT_W = REG_COUNT * 8;

  logic       take;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       cp_byte_en;
  logic       cp_last;
  logic       cp_valid;
  copy_req_t  cp_req;
  logic [FLAT_W-1:0] act_flat;

  assign in_ready = !cp_valid;
  assign take     = in_valid && in_ready;

  csd_parser #(.OPND_LEN(COPY_LEN)) u_parser (
    .clk          (clk),
    .rst          (rst),
    .byte_i       (in_data),
    .take_i       (take),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .cp_byte_en_o (cp_byte_en),
    .cp_last_o    (cp_last),
    .err_o        (cmd_error)
  );

  csd_regfile #(.REG_COUNT(REG_COUNT), .DW(8)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .locked_o   (vid_locked),
    .act_flat_o (act_flat)
  );

  csd_copy_port #(.OPND_LEN(COPY_LEN)) u_copy (
    .clk         (clk),
    .rst         (rst),
    .byte_i      (in_data),
    .byte_en_i   (cp_byte_en),
    .last_i      (cp_last),
    .req_ready_i (copy_ready),
    .req_valid_o (cp_valid),
    .req_o       (cp_req)
  );

  assign active_regs = act_flat;
  assign depth_sel   = act_flat[DEPTH_IDX*8 +: 8];
  assign base_16bpp  = {act_flat[B16_IDX*8 +: 8], act_flat[(B16_IDX+1)*8 +: 8],
                        act_flat[(B16_IDX+2)*8 +: 8]};
  assign base_8bpp   = {act_flat[B8_IDX*8 +: 8], act_flat[(B8_IDX+1)*8 +: 8],
                        act_flat[(B8_IDX+2)*8 +: 8]};
  assign copy_valid  = cp_valid;
  assign copy_src    = cp_req.src;
  assign copy_count  = cp_req.cnt;
  assign copy_dst    = cp_req.dst;

  if (REG_COUNT < MIN_REGS || REG_COUNT > 256) begin : g_bad_cfg
    initial $error("REG_COUNT must be between %0d and 256", MIN_REGS);
  end
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int FLAT_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              copy_valid,
  input logic              copy_ready,
  input logic [23:0]       copy_src,
  input logic [7:0]        copy_count,
  input logic [23:0]       copy_dst,
  input logic              vid_locked,
  input logic              cmd_error,
  input logic [FLAT_W-1:0] active_regs
);
  // R7: pending request holds its fields until accepted
  a_r7_hold_fields: assert property (@(posedge clk) disable iff (rst)
    copy_valid && !copy_ready |=> copy_valid && $stable(copy_src)
                                  && $stable(copy_count) && $stable(copy_dst));

  // R7: stream stalls while the request waits
  a_r7_stall_input: assert property (@(posedge clk) disable iff (rst)
    copy_valid && !copy_ready |=> !in_ready);

  // R7: acceptance retires the request
  a_r7_retire: assert property (@(posedge clk) disable iff (rst)
    copy_valid && copy_ready |=> !copy_valid);

  // R3: active set frozen while locked
  a_r3_locked_freeze: assert property (@(posedge clk) disable iff (rst)
    vid_locked |=> (!vid_locked || $stable(active_regs)));

  // R12: error is sticky
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cmd_error |=> cmd_error);
endmodule

bind cmd_stream_decoder csd_checker #(.FLAT_W(REG_COUNT*8)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .copy_valid  (copy_valid),
  .copy_ready  (copy_ready),
  .copy_src    (copy_src),
  .copy_count  (copy_count),
  .copy_dst    (copy_dst),
  .vid_locked  (vid_locked),
  .cmd_error   (cmd_error),
  .active_regs (active_regs)
);

// File: tb/tb_cmd_stream_decoder.sv
module tb_cmd_stream_decoder;
  localparam int NREG = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NREG*8-1:0] active_regs;
  logic [7:0] depth_sel;
  logic [23:0] base_16bpp, base_8bpp;
  logic vid_locked, copy_valid, copy_ready, cmd_error;
  logic [23:0] copy_src, copy_dst;
  logic [7:0] copy_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  cmd_stream_decoder #(.REG_COUNT(NREG)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .active_regs(active_regs), .depth_sel(depth_sel),
    .base_16bpp(base_16bpp), .base_8bpp(base_8bpp), .vid_locked(vid_locked),
    .copy_valid(copy_valid), .copy_ready(copy_ready), .copy_src(copy_src),
    .copy_count(copy_count), .copy_dst(copy_dst), .cmd_error(cmd_error)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(int a);
    return active_regs[a*8 +: 8];
  endfunction

  task automatic check_all(string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < NREG; a++) begin
      if (reg_of(a) !== model[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: reg 0x%0h actual 0x%0h expected 0x%0h (%0d mismatches)",
               req, first, reg_of(first), model[first], bad);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] v);
    send(8'hAF); send(8'h20); send(a); send(v);
    settle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    copy_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < NREG; a++) model[a] = 8'h00;
  endtask

  task automatic send_copy(logic [23:0] s, logic [7:0] n, logic [23:0] d);
    send(8'hAF); send(8'h6A);
    send(s[23:16]); send(s[15:8]); send(s[7:0]);
    send(n);
    send(d[23:16]); send(d[15:8]); send(d[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    copy_ready = 1'b0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", 64'(in_ready), 64'd1);
    check("R1 copy_valid", 64'(copy_valid), 64'd0);
    check("R1 cmd_error", 64'(cmd_error), 64'd0);
    check("R1 vid_locked", 64'(vid_locked), 64'd0);
    check_all("R1 active regs zero");

    // R2 unlocked sweep over every register
    for (int a = 0; a < NREG; a++) begin
      logic [7:0] v = 8'((a * 5 + 3) & 8'hFF);
      wr(8'(a), v);
      model[a] = v;
      check("R2 direct write", 64'(reg_of(a)), 64'(v));
    end
    check_all("R2 sweep no disturbance");

    // R5 decoded fields
    wr(8'h00, 8'h01); model[0] = 8'h01;
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'h9A); wr(8'h27, 8'hBC); wr(8'h28, 8'hDE);
    model[32] = 8'h12; model[33] = 8'h34; model[34] = 8'h56;
    model[38] = 8'h9A; model[39] = 8'hBC; model[40] = 8'hDE;
    check("R5 depth_sel", 64'(depth_sel), 64'h01);
    check("R5 base_16bpp", 64'(base_16bpp), 64'h123456);
    check("R5 base_8bpp", 64'(base_8bpp), 64'h9ABCDE);

    // R3 lock then stage a new value in every register
    wr(8'hFF, 8'h00);
    check("R3 locked", 64'(vid_locked), 64'd1);
    for (int a = 0; a < NREG; a++) begin
      wr(8'(a), 8'((a * 7) ^ 8'hC3));
      if (a == 5) check("R3 staged write hidden", 64'(reg_of(5)), 64'(model[5]));
    end
    check_all("R3 active frozen while locked");

    // R4 unlock: all staged values on the unlock edge
    send(8'hAF); send(8'h20); send(8'hFF);
    send(8'hFF);
    #1;
    for (int a = 0; a < NREG; a++) model[a] = 8'((a * 7) ^ 8'hC3);
    check_all("R4 unlock same edge");
    check("R4 unlocked", 64'(vid_locked), 64'd0);
    settle();
    check("R5 base_16bpp after unlock", 64'(base_16bpp),
          64'({model[32], model[33], model[34]}));
    check("R5 base_8bpp after unlock", 64'(base_8bpp),
          64'({model[38], model[39], model[40]}));

    // R11 other lock values and out-of-range addresses
    wr(8'hFF, 8'h55);
    check("R11 odd lock value unlocked", 64'(vid_locked), 64'd0);
    wr(8'h40, 8'h11);
    wr(8'hFE, 8'h22);
    check_all("R11 out of range unlocked");
    wr(8'hFF, 8'h00);
    wr(8'hFF, 8'h55);
    check("R11 odd lock value locked", 64'(vid_locked), 64'd1);
    wr(8'h80, 8'h33);
    wr(8'hFF, 8'hFF);
    check_all("R11 out of range staged");

    // R6 / R7 copy requests with varying consumer delay
    for (int k = 0; k < 4; k++) begin
      logic [23:0] s = 24'(24'h010203 * (k + 1)) ^ 24'(k << 20);
      logic [7:0]  n = 8'(k * 61 + 1);
      logic [23:0] d = s ^ 24'hA5A5A5;
      send_copy(s, n, d);
      settle();
      check("R6 copy_valid", 64'(copy_valid), 64'd1);
      check("R6 copy_src", 64'(copy_src), 64'(s));
      check("R6 copy_count", 64'(copy_count), 64'(n));
      check("R6 copy_dst", 64'(copy_dst), 64'(d));
      for (int w = 0; w < k; w++) begin
        @(negedge clk);
        check("R7 stalled", 64'(in_ready), 64'd0);
        check("R7 held src", 64'(copy_src), 64'(s));
      end
      copy_ready = 1'b1;
      @(negedge clk);
      copy_ready = 1'b0;
      check("R7 retired", 64'(copy_valid), 64'd0);
      check("R7 ready again", 64'(in_ready), 64'd1);
    end

    // R7 register write queued behind a pending request
    fork
      begin
        send_copy(24'hABCDEF, 8'h10, 24'h000102);
        send(8'hAF); send(8'h20); send(8'h05); send(8'h77);
        settle();
      end
      begin
        repeat (14) @(negedge clk);
        check("R7 queued write blocked", 64'(reg_of(5)), 64'(model[5]));
        check("R7 stall with pending", 64'(in_ready), 64'd0);
        copy_ready = 1'b1;
        @(negedge clk);
        copy_ready = 1'b0;
      end
    join
    model[5] = 8'h77;
    check("R7 queued write lands", 64'(reg_of(5)), 64'h77);

    // R8 repeated marker
    send(8'hAF); send(8'hAF); send(8'h20); send(8'h07); send(8'h99);
    settle();
    model[7] = 8'h99;
    check("R8 double marker write", 64'(reg_of(7)), 64'h99);
    check("R8 no error", 64'(cmd_error), 64'd0);

    // R10 unknown opcode, drop, recover
    send(8'hAF); send(8'h33);
    settle();
    check("R10 error raised", 64'(cmd_error), 64'd1);
    send(8'h20); send(8'h08); send(8'h11);
    settle();
    check("R10 dropped bytes", 64'(reg_of(8)), 64'(model[8]));
    wr(8'h08, 8'h22);
    model[8] = 8'h22;
    check("R10 recovery", 64'(reg_of(8)), 64'h22);
    check("R12 sticky error", 64'(cmd_error), 64'd1);
    check_all("R10 register file intact");

    // R9 bad marker after reset
    do_reset();
    @(negedge clk);
    check("R12 cleared by reset", 64'(cmd_error), 64'd0);
    send(8'h20); send(8'h09); send(8'h44);
    settle();
    check("R9 error raised", 64'(cmd_error), 64'd1);
    check("R9 embedded write ignored", 64'(reg_of(9)), 64'h00);
    wr(8'h09, 8'h45);
    check("R9 recovery", 64'(reg_of(9)), 64'h45);
    check("R12 sticky after good command", 64'(cmd_error), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule